// File: doc/BRIEF.md
# Processor Operating Mode Decoder

This block turns a handful of architectural control bits into one cached summary word that describes how the processor is currently executing. The inputs are:

- the long-mode-active bit;
- the protection-enable and paging bits of the first control register;
- the code segment's long flag, default-size flag and privilege level;
- the stack segment's default-size flag;
- the virtual-8086 flag of the flags register.

From these, combinational logic picks a top-level mode (long or legacy) and one of five submodes. It then derives the default and alternate operand sizes, the default and alternate address sizes, and the stack width, all expressed in bytes.

The result is held in a summary register. That register loads only on a cycle when the update strobe is high. Control logic pulses the strobe after writing any of the contributing state. Downstream decode logic then reads a stable, pre-digested view of the mode without reevaluating the rules itself.

Top module: `opmode_decoder`

## Requirements
- R1: While reset is asserted, and after it until the first update, the summary reads legacy mode, real submode, privilege 0, paging 0, operand 2/4, address 2/4, stack 2. The summary word layout is: [26] mode (long=0, legacy=1), [25:23] submode (64-bit=0, compatibility=1, protected=2, virtual-8086=3, real=4), [22:21] privilege, [20] paging, [19:16] default operand size, [15:12] alternate operand size, [11:8] default address size, [7:4] alternate address size, [3:0] stack size.
- R2: On a clock edge where the update strobe is low, the summary keeps its value whatever the other inputs do.
- R3: When long-mode-active is 1 at an update, the mode is long (0). The submode is 64-bit (0) if the code segment long flag is 1, and compatibility (1) otherwise.
- R4: When long-mode-active is 0 at an update, the mode is legacy (1). The submode is real (4) if protection enable is 0, regardless of the virtual-8086 flag. It is virtual-8086 (3) if protection enable and the virtual-8086 flag are both 1, and protected (2) otherwise.
- R5: At an update, the privilege field takes the code segment privilege level and the paging field takes the paging bit.
- R6: Operand size default/alternate is 4/2 in 64-bit submode or when the code segment default-size flag is 1, and 2/4 otherwise.
- R7: Address size default/alternate is 8/4 in 64-bit submode, 4/2 when the code segment default-size flag is 1 outside 64-bit submode, and 2/4 otherwise.
- R8: Stack size is 8 in 64-bit submode, 4 when the stack segment default-size flag is 1 outside 64-bit submode, and 2 otherwise. The code segment default-size flag has no effect on it.
- R9: Inputs are sampled at the edge where the update strobe is high. The new summary appears after that edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, already released in step with clk |
| update_i | input | 1 | Load the summary register this cycle |
| long_act_i | input | 1 | Long mode active |
| prot_en_i | input | 1 | Protection enable |
| paging_i | input | 1 | Paging enable |
| cs_lmode_i | input | 1 | Code segment long-mode flag |
| cs_dsize_i | input | 1 | Code segment default-size flag |
| cs_priv_i | input | 2 | Code segment privilege level |
| ss_dsize_i | input | 1 | Stack segment default-size flag |
| v86_flag_i | input | 1 | Virtual-8086 flag |
| summary_o | output | 27 | Registered summary word |

## Verification
The assertions assume that rst_n arrives already synchronized to clk. They also assume that every input is a known 0 or 1 at each edge where the update strobe is high; no other input condition is excluded. The bench meets these assumptions by driving all inputs only on the falling edge and keeping them two-valued throughout. Random draws cover every input combination, including combinations that architecture software would not normally produce, such as the long flag set while long mode is inactive. Directed cases aim at protection enable being 0 while the virtual-8086 flag is 1, and at the stack flag differing from the code flag.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
  localparam int SZ_W  = 4;
  localparam int CPL_W = 2;

  typedef enum logic {
    MODE_LONG   = 1'b0,
    MODE_LEGACY = 1'b1
  } mode_e;

  typedef enum logic [2:0] {
    SUB_64     = 3'd0,
    SUB_COMPAT = 3'd1,
    SUB_PROT   = 3'd2,
    SUB_V86    = 3'd3,
    SUB_REAL   = 3'd4
  } sub_e;

  typedef struct packed {
    mode_e             mode;
    sub_e              sub;
    logic [CPL_W-1:0]  cpl;
    logic              paging;
    logic [SZ_W-1:0]   op_dflt;
    logic [SZ_W-1:0]   op_alt;
    logic [SZ_W-1:0]   ad_dflt;
    logic [SZ_W-1:0]   ad_alt;
    logic [SZ_W-1:0]   stk;
  } summary_t;

  localparam int SUM_W = $bits(summary_t);

  localparam logic [SZ_W-1:0] BYTES2 = SZ_W'(2);
  localparam logic [SZ_W-1:0] BYTES4 = SZ_W'(4);
  localparam logic [SZ_W-1:0] BYTES8 = SZ_W'(8);

  localparam summary_t SUMMARY_RST = '{
    mode:    MODE_LEGACY,
    sub:     SUB_REAL,
    cpl:     '0,
    paging:  1'b0,
    op_dflt: BYTES2,
    op_alt:  BYTES4,
    ad_dflt: BYTES2,
    ad_alt:  BYTES4,
    stk:     BYTES2
  };
endpackage

// File: rtl/opmode_classify.sv
module opmode_classify
  import opmode_pkg::*;
(
  input  logic  long_act_i,
  input  logic  prot_en_i,
  input  logic  cs_lmode_i,
  input  logic  v86_flag_i,
  output mode_e mode_o,
  output sub_e  sub_o
);
  always_comb begin
    if (long_act_i) begin
      mode_o = MODE_LONG;
      sub_o  = cs_lmode_i ? SUB_64 : SUB_COMPAT;
    end else begin
      mode_o = MODE_LEGACY;
      if (!prot_en_i)      sub_o = SUB_REAL;
      else if (v86_flag_i) sub_o = SUB_V86;
      else                 sub_o = SUB_PROT;
    end
  end
endmodule

// File: rtl/opmode_sizes.sv
module opmode_sizes
  import opmode_pkg::*;
(
  input  sub_e             sub_i,
  input  logic             cs_dsize_i,
  input  logic             ss_dsize_i,
  output logic [SZ_W-1:0]  op_dflt_o,
  output logic [SZ_W-1:0]  op_alt_o,
  output logic [SZ_W-1:0]  ad_dflt_o,
  output logic [SZ_W-1:0]  ad_alt_o,
  output logic [SZ_W-1:0]  stk_o
);
  logic wide64;
  assign wide64 = (sub_i == SUB_64);

  // operand width: 64-bit submode behaves like a wide code segment
  always_comb begin
    if (wide64 || cs_dsize_i) begin
      op_dflt_o = BYTES4;
      op_alt_o  = BYTES2;
    end else begin
      op_dflt_o = BYTES2;
      op_alt_o  = BYTES4;
    end
  end

  // address width: three tiers
  always_comb begin
    if (wide64) begin
      ad_dflt_o = BYTES8;
      ad_alt_o  = BYTES4;
    end else if (cs_dsize_i) begin
      ad_dflt_o = BYTES4;
      ad_alt_o  = BYTES2;
    end else begin
      ad_dflt_o = BYTES2;
      ad_alt_o  = BYTES4;
    end
  end

  // stack width follows the stack segment, not the code segment
  always_comb begin
    if (wide64)          stk_o = BYTES8;
    else if (ss_dsize_i) stk_o = BYTES4;
    else                 stk_o = BYTES2;
  end
endmodule

// File: rtl/opmode_summary_reg.sv
module opmode_summary_reg
  import opmode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  summary_t next_i,
  output summary_t q_o
);
  summary_t q_d;

  always_comb begin
    q_d = q_o;
    if (load_i) q_d = next_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= SUMMARY_RST;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/opmode_decoder.sv
module opmode_decoder
  import opmode_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   update_i,
  input  logic                   long_act_i,
  input  logic                   prot_en_i,
  input  logic                   paging_i,
  input  logic                   cs_lmode_i,
  input  logic                   cs_dsize_i,
  input  logic [CPL_W-1:0]       cs_priv_i,
  input  logic                   ss_dsize_i,
  input  logic                   v86_flag_i,
  output logic [SUM_W-1:0]       summary_o
);
  mode_e           mode_c;
  sub_e            sub_c;
  logic [SZ_W-1:0] op_dflt_c, op_alt_c, ad_dflt_c, ad_alt_c, stk_c;
  summary_t        next_c;
  summary_t        held_q;

  opmode_classify u_classify (
    .long_act_i (long_act_i),
    .prot_en_i  (prot_en_i),
    .cs_lmode_i (cs_lmode_i),
    .v86_flag_i (v86_flag_i),
    .mode_o     (mode_c),
    .sub_o      (sub_c)
  );

  opmode_sizes u_sizes (
    .sub_i      (sub_c),
    .cs_dsize_i (cs_dsize_i),
    .ss_dsize_i (ss_dsize_i),
    .op_dflt_o  (op_dflt_c),
    .op_alt_o   (op_alt_c),
    .ad_dflt_o  (ad_dflt_c),
    .ad_alt_o   (ad_alt_c),
    .stk_o      (stk_c)
  );

  always_comb begin
    next_c.mode    = mode_c;
    next_c.sub     = sub_c;
    next_c.cpl     = cs_priv_i;
    next_c.paging  = paging_i;
    next_c.op_dflt = op_dflt_c;
    next_c.op_alt  = op_alt_c;
    next_c.ad_dflt = ad_dflt_c;
    next_c.ad_alt  = ad_alt_c;
    next_c.stk     = stk_c;
  end

  opmode_summary_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (update_i),
    .next_i (next_c),
    .q_o    (held_q)
  );

  assign summary_o = held_q;
endmodule

// File: rtl/opmode_decoder_chk.sv
module opmode_decoder_chk
  import opmode_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              update_i,
  input logic              long_act_i,
  input logic              prot_en_i,
  input logic              paging_i,
  input logic              cs_lmode_i,
  input logic              cs_dsize_i,
  input logic [CPL_W-1:0]  cs_priv_i,
  input logic              ss_dsize_i,
  input logic              v86_flag_i,
  input logic [SUM_W-1:0]  summary_o
);
  summary_t s;
  assign s = summary_t'(summary_o);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update_i |=> $stable(summary_o));

  // R3
  long_submode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (update_i && long_act_i) |=>
      (s.mode == MODE_LONG) && (s.sub == ($past(cs_lmode_i) ? SUB_64 : SUB_COMPAT)));

  // R4
  real_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (update_i && !long_act_i && !prot_en_i) |=>
      (s.mode == MODE_LEGACY) && (s.sub == SUB_REAL));

  // R4
  v86_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (update_i && !long_act_i && prot_en_i && v86_flag_i) |=> (s.sub == SUB_V86));

  // R5
  priv_paging_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_i |=> (s.cpl == $past(cs_priv_i)) && (s.paging == $past(paging_i)));

  // R6
  op_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_i |=> (s.op_dflt == ((s.sub == SUB_64 || $past(cs_dsize_i)) ? BYTES4 : BYTES2)));

  // R8
  narrow_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (update_i && !long_act_i && !ss_dsize_i) |=> (s.stk == BYTES2));
endmodule

bind opmode_decoder opmode_decoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .update_i   (update_i),
  .long_act_i (long_act_i),
  .prot_en_i  (prot_en_i),
  .paging_i   (paging_i),
  .cs_lmode_i (cs_lmode_i),
  .cs_dsize_i (cs_dsize_i),
  .cs_priv_i  (cs_priv_i),
  .ss_dsize_i (ss_dsize_i),
  .v86_flag_i (v86_flag_i),
  .summary_o  (summary_o)
);

// File: tb/tb_opmode_decoder.sv
`timescale 1ns/1ps
module tb_opmode_decoder;
  logic clk = 1'b0;
  logic rst_n;
  logic update_i, long_act_i, prot_en_i, paging_i, cs_lmode_i, cs_dsize_i, ss_dsize_i, v86_flag_i;
  logic [1:0]  cs_priv_i;
  logic [26:0] summary_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [26:0] exp_q;

  always #10 clk = ~clk;

  opmode_decoder dut (
    .clk(clk), .rst_n(rst_n), .update_i(update_i), .long_act_i(long_act_i),
    .prot_en_i(prot_en_i), .paging_i(paging_i), .cs_lmode_i(cs_lmode_i),
    .cs_dsize_i(cs_dsize_i), .cs_priv_i(cs_priv_i), .ss_dsize_i(ss_dsize_i),
    .v86_flag_i(v86_flag_i), .summary_o(summary_o)
  );

  localparam logic [26:0] RST_WORD = {1'b1, 3'd4, 2'd0, 1'b0, 4'd2, 4'd4, 4'd2, 4'd4, 4'd2};

  function automatic logic [26:0] model(input logic la, pe, pg, csl, csd,
                                        input logic [1:0] cpl, input logic ssd, v86);
    logic md; logic [2:0] sb; logic [3:0] od, oa, ad, aa, st;
    if (la) begin md = 1'b0; sb = csl ? 3'd0 : 3'd1; end
    else begin
      md = 1'b1;
      sb = !pe ? 3'd4 : (v86 ? 3'd3 : 3'd2);
    end
    if (sb == 3'd0 || csd) begin od = 4; oa = 2; end else begin od = 2; oa = 4; end
    if (sb == 3'd0) begin ad = 8; aa = 4; end
    else if (csd) begin ad = 4; aa = 2; end
    else begin ad = 2; aa = 4; end
    if (sb == 3'd0) st = 8; else if (ssd) st = 4; else st = 2;
    return {md, sb, cpl, pg, od, oa, ad, aa, st};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string modetag);
    check(modetag, {5'd0, summary_o}, {5'd0, exp_q});
    check("R5", {29'd0, summary_o[22:20]}, {29'd0, exp_q[22:20]});
    check("R6", {24'd0, summary_o[19:12]}, {24'd0, exp_q[19:12]});
    check("R7", {24'd0, summary_o[11:4]}, {24'd0, exp_q[11:4]});
    check("R8", {28'd0, summary_o[3:0]}, {28'd0, exp_q[3:0]});
  endtask

  // drive at negedge, clock one edge, sample at the following negedge
  task automatic step(input logic upd, la, pe, pg, csl, csd, input logic [1:0] cpl,
                      input logic ssd, v86);
    update_i = upd; long_act_i = la; prot_en_i = pe; paging_i = pg; cs_lmode_i = csl;
    cs_dsize_i = csd; cs_priv_i = cpl; ss_dsize_i = ssd; v86_flag_i = v86;
    if (upd) exp_q = model(la, pe, pg, csl, csd, cpl, ssd, v86);
    @(posedge clk);
    @(negedge clk);
    check_all(!upd ? "R2" : (la ? "R3" : "R4"));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0DEC_0DE5));
    rst_n = 1'b0;
    {update_i, long_act_i, prot_en_i, paging_i, cs_lmode_i, cs_dsize_i, ss_dsize_i, v86_flag_i} = '0;
    cs_priv_i = 2'd0;
    exp_q = RST_WORD;
    repeat (3) @(negedge clk);
    check("R1", {5'd0, summary_o}, {5'd0, RST_WORD});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {5'd0, summary_o}, {5'd0, RST_WORD});

    // R1 still holds until the first update: idle step with busy inputs
    step(1'b0, 1, 1, 1, 1, 1, 2'd3, 1, 1);
    check("R1", {5'd0, summary_o}, {5'd0, RST_WORD});

    // R4: protection off beats the virtual-8086 flag
    step(1'b1, 0, 0, 1, 0, 0, 2'd2, 0, 1);
    // R4: virtual-8086
    step(1'b1, 0, 1, 0, 0, 0, 2'd3, 0, 1);
    // R4 protected, R8: wide stack with narrow code segment
    step(1'b1, 0, 1, 1, 0, 0, 2'd1, 1, 0);
    // R8: wide code segment does not widen the stack
    step(1'b1, 0, 1, 1, 0, 1, 2'd0, 0, 0);
    // R3/R6/R7/R8: 64-bit submode
    step(1'b1, 1, 1, 1, 1, 0, 2'd3, 0, 0);
    // R3: compatibility with wide code, narrow stack
    step(1'b1, 1, 1, 1, 0, 1, 2'd0, 0, 1);
    // R2: idle edge with very different inputs
    step(1'b0, 0, 0, 0, 0, 0, 2'd1, 1, 1);

    // R9: inputs present with strobe but before the edge, no change yet
    update_i = 1'b1; long_act_i = 1'b1; prot_en_i = 1'b1; paging_i = 1'b0; cs_lmode_i = 1'b1;
    cs_dsize_i = 1'b1; cs_priv_i = 2'd2; ss_dsize_i = 1'b1; v86_flag_i = 1'b0;
    #5;
    check("R9", {5'd0, summary_o}, {5'd0, exp_q});
    exp_q = model(1, 1, 0, 1, 1, 2'd2, 1, 0);
    @(posedge clk);
    #2;
    check("R9", {5'd0, summary_o}, {5'd0, exp_q});
    @(negedge clk);

    for (int i = 0; i < 500; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      step(($urandom % 4) != 0, r[0], r[1], r[2], r[3], r[4], r[6:5], r[7], r[8]);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule